// File: doc/BRIEF.md
# Eight-bit accumulator ALU with registered flags

This block is the arithmetic and logic engine of a small accumulator processor. A single eight-bit data input serves both operands. On one cycle the value on that input is captured into an internal operand register (the B operand). On a later cycle an operation strobe uses the data input as the A operand. The selected result and the two status flags, zero and carry, are then captured on the rising clock edge. The flags go straight to the sequencing logic for conditional branches. No other logic reads them.

A three-bit mode field selects one of eight operations: add with carry, subtract with borrow, increment, decrement, AND, OR, XOR, and shift right through the carry. Subtraction works by adding the inverted B operand plus the carry, so the carry flag acts as an inverted borrow. Increment and decrement ignore B and force the carry-in, so they need only a single cycle. A separate compare input turns any operation strobe into a subtract with the carry-in forced high. It updates the flags and leaves the result register untouched. Two control lines set or clear the carry flag between operations, and a clear wins over a set. A shift left is done as an add of the accumulator to itself.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low, the result register, the B operand register, the zero flag and the carry flag all become 0.
- R2: When load_b is high on a clock edge, the B operand register captures data_in. An operation on that same edge uses the B value from before the edge.
- R3: With op_go high, cmp_en low and mode 000 (add), result becomes (A + B + carry) mod 256, and the carry flag becomes bit 8 of that sum.
- R4: With mode 001 (subtract), result becomes (A + ~B + carry) mod 256, and the carry flag becomes the carry out. It is 0 exactly when A - B - (1 - carry) is negative.
- R5: Mode 010 (increment) gives A + 1 and sets carry only when A is 0xFF. Mode 011 (decrement) gives A - 1 and clears carry only when A is 0x00. Neither result depends on B or on the old carry.
- R6: Modes 100, 101 and 110 give A AND B, A OR B and A XOR B, and they leave the carry flag unchanged.
- R7: Mode 111 (shift right) gives the old carry in bit 7 and A[7:1] in bits 6..0. The carry flag becomes A[0].
- R8: With op_go and cmp_en both high, the flags take the values of A + ~B + 1, whatever the mode and the old carry are. The result register keeps its value.
- R9: Every operation strobe sets the zero flag to 1 when the eight-bit value it produced (the result, or the compare difference) is 0x00, and clears it otherwise.
- R10: When op_go is low, carry_clr clears the carry flag, and otherwise carry_set sets it. A clear takes priority when both are high. Neither changes the result or the zero flag. While op_go is high, both lines are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 8 | Shared operand input: B when load_b is high, A when op_go is high |
| load_b | input | 1 | Capture data_in into the B operand register |
| op_go | input | 1 | Perform the operation chosen by mode on this edge |
| mode | input | 3 | Operation select (encoding in R3 to R7) |
| cmp_en | input | 1 | Turn the operation into a compare that updates only the flags |
| carry_set | input | 1 | Set the carry flag when no operation runs |
| carry_clr | input | 1 | Clear the carry flag when no operation runs; wins over carry_set |
| result | output | 8 | Registered operation result |
| zero_flag | output | 1 | Registered zero flag |
| carry_flag | output | 1 | Registered carry / inverted-borrow flag |

## Verification
The hardest case to reach is the carry that an operation consumes. It is set only by earlier operations or by the set and clear lines, so every carry-in combination must be staged on purpose. Each swept operation therefore takes two steps. The first cycle loads B and forces the carry to the wanted value through the set or clear line, and the second cycle fires the operation. This covers all 256 A values, both carry-in values and a set of edge B values. A compare that leaves the result register unchanged is made visible by checking that the result from the previous non-compare operation is still present. Conflicting set and clear requests, and set requests that arrive with an operation strobe, are driven directly, and their effect is read on the carry flag.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADC = 3'b000,
    OP_SBC = 3'b001,
    OP_INC = 3'b010,
    OP_DEC = 3'b011,
    OP_AND = 3'b100,
    OP_OR  = 3'b101,
    OP_XOR = 3'b110,
    OP_SHR = 3'b111
  } alu_op_e;

  // Logic-path sub-selects (low two mode bits when mode[2] is set)
  localparam logic [1:0] LSEL_AND = 2'b00;
  localparam logic [1:0] LSEL_OR  = 2'b01;
  localparam logic [1:0] LSEL_XOR = 2'b10;
  localparam logic [1:0] LSEL_SHR = 2'b11;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sub_mode,
  input  logic         cmp,
  input  logic         carry_q,
  output logic [W-1:0] sum,
  output logic         cout
);

  // Full-width add with carry-in; top bit is the carry out
  function automatic logic [W:0] add_with_cin(input logic [W-1:0] x,
                                              input logic [W-1:0] y,
                                              input logic         c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  logic         zero_b;   // replace B by zero (increment/decrement)
  logic         invert_b; // ones' complement of the conditioned B
  logic [W-1:0] b_cond;
  logic         cin;
  logic [W:0]   wide;

  always_comb begin
    zero_b   = sub_mode[1] & ~cmp;
    invert_b = sub_mode[0] | cmp;
    b_cond   = zero_b ? '0 : b;
    b_cond   = invert_b ? ~b_cond : b_cond;
    if (cmp)              cin = 1'b1;
    else if (sub_mode[1]) cin = ~sub_mode[0];
    else                  cin = carry_q;
    wide = add_with_cin(a, b_cond, cin);
  end

  assign sum  = wide[W-1:0];
  assign cout = wide[W];

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   lsel,
  input  logic         carry_q,
  output logic [W-1:0] lout,
  output logic         shift_out
);

  function automatic logic [W-1:0] shr_through(input logic [W-1:0] x,
                                               input logic         c);
    return {c, x[W-1:1]};
  endfunction

  always_comb begin
    unique case (lsel)
      LSEL_AND: lout = a & b;
      LSEL_OR:  lout = a | b;
      LSEL_XOR: lout = a ^ b;
      default:  lout = shr_through(a, carry_q);
    endcase
  end

  assign shift_out = a[0];

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_in,
  input  logic         load_b,
  input  logic         op_go,
  input  logic [2:0]   mode,
  input  logic         cmp_en,
  input  logic         carry_set,
  input  logic         carry_clr,
  output logic [W-1:0] result,
  output logic         zero_flag,
  output logic         carry_flag
);

  alu_op_e      op;
  logic [W-1:0] b_q;
  logic [W-1:0] res_q;
  logic         z_q;
  logic         c_q;

  logic [W-1:0] arith_sum;
  logic         arith_cout;
  logic [W-1:0] logic_val;
  logic         shift_cout;

  // Named internal events for the checker
  logic         use_logic;   // logic path drives the produced value
  logic         res_write;   // result register captures this edge
  logic         flag_update; // flags follow an operation this edge
  logic [W-1:0] produced;
  logic         c_d;

  assign op = alu_op_e'(mode);

  acc_alu_arith #(.W(W)) u_arith (
    .a        (data_in),
    .b        (b_q),
    .sub_mode (mode[1:0]),
    .cmp      (cmp_en),
    .carry_q  (c_q),
    .sum      (arith_sum),
    .cout     (arith_cout)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .a         (data_in),
    .b         (b_q),
    .lsel      (mode[1:0]),
    .carry_q   (c_q),
    .lout      (logic_val),
    .shift_out (shift_cout)
  );

  assign use_logic   = mode[2] & ~cmp_en;
  assign produced    = use_logic ? logic_val : arith_sum;
  assign res_write   = op_go & ~cmp_en;
  assign flag_update = op_go;

  always_comb begin
    c_d = c_q;
    if (flag_update) begin
      if (!use_logic)        c_d = arith_cout;
      else if (op == OP_SHR) c_d = shift_cout;
    end else if (carry_clr) begin
      c_d = 1'b0;
    end else if (carry_set) begin
      c_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_q   <= '0;
      res_q <= '0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
    end else begin
      if (load_b)      b_q   <= data_in;
      if (res_write)   res_q <= produced;
      if (flag_update) z_q   <= (produced == '0);
      c_q <= c_d;
    end
  end

  assign result     = res_q;
  assign zero_flag  = z_q;
  assign carry_flag = c_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] data_in,
  input logic         op_go,
  input logic [2:0]   mode,
  input logic         cmp_en,
  input logic         carry_set,
  input logic         carry_clr,
  input logic [W-1:0] result,
  input logic         zero_flag,
  input logic         carry_flag,
  input logic         res_write
);

  localparam logic [W-1:0] ONE = W'(1);

  // R9
  zero_matches_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && !cmp_en) |=> (zero_flag == (result == '0)));

  // R6
  logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && !cmp_en && mode[2] && (mode != 3'b111)) |=> $stable(carry_flag));

  // R8
  compare_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && cmp_en) |=> $stable(result));

  // R10
  idle_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_write |=> $stable(result));

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_go && carry_clr) |=> !carry_flag);

  // R10
  set_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_go && carry_set && !carry_clr) |=> carry_flag);

  // R5
  inc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && !cmp_en && mode == 3'b010) |=> (result == $past(data_in) + ONE));

  // R7
  shr_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && !cmp_en && mode == 3'b111)
      |=> (carry_flag == $past(data_in[0])) && (result[W-1] == $past(carry_flag)));

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_acc_alu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_in    (data_in),
  .op_go      (op_go),
  .mode       (mode),
  .cmp_en     (cmp_en),
  .carry_set  (carry_set),
  .carry_clr  (carry_clr),
  .result     (result),
  .zero_flag  (zero_flag),
  .carry_flag (carry_flag),
  .res_write  (res_write)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] data_in;
  logic       load_b, op_go, cmp_en, carry_set, carry_clr;
  logic [2:0] mode;
  logic [7:0] result;
  logic       zero_flag, carry_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench-side model state
  int exp_res = 0;
  int exp_c   = 0;

  always #5 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .load_b(load_b),
    .op_go(op_go), .mode(mode), .cmp_en(cmp_en), .carry_set(carry_set),
    .carry_clr(carry_clr), .result(result), .zero_flag(zero_flag),
    .carry_flag(carry_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int bpick(input int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h7F;  3: return 8'h80;
      4: return 8'hFF;  5: return 8'h55;  6: return 8'hAA;  default: return 8'h0F;
    endcase
  endfunction

  // Cycle 1: load B and stage the carry; cycle 2: fire the operation.
  task automatic do_op(input int a, input int b, input int m,
                       input bit cmpf, input int cin, input string tag);
    int s, r, c;
    data_in = 8'(b); load_b = 1'b1; op_go = 1'b0; cmp_en = 1'b0;
    carry_set = (cin == 1); carry_clr = (cin == 0);
    @(negedge clk);
    check({tag, " R10 staged carry"}, int'(carry_flag), cin);
    load_b = 1'b0; carry_set = 1'b0; carry_clr = 1'b0;
    data_in = 8'(a); mode = 3'(m); cmp_en = cmpf; op_go = 1'b1;
    if (cmpf) begin
      s = a - b + 256; r = s % 256; c = (s >= 256);
    end else begin
      case (m)
        0: begin s = a + b + cin;             r = s % 256; c = s / 256; end
        1: begin s = a - b - (1 - cin) + 256; r = s % 256; c = (s >= 256); end
        2: begin r = (a + 1) % 256;           c = (a == 255); end
        3: begin r = (a + 255) % 256;         c = (a != 0); end
        4: begin r = a & b;                   c = cin; end
        5: begin r = a | b;                   c = cin; end
        6: begin r = a ^ b;                   c = cin; end
        default: begin r = cin * 128 + a / 2; c = a % 2; end
      endcase
    end
    @(negedge clk);
    op_go = 1'b0; cmp_en = 1'b0;
    if (!cmpf) exp_res = r;
    exp_c = c;
    check({tag, " result"}, int'(result), exp_res);
    check({tag, " R9 zero"}, int'(zero_flag), int'(r == 0));
    check({tag, " carry"}, int'(carry_flag), exp_c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; data_in = 8'hA5; load_b = 1'b1; op_go = 1'b1; mode = 3'b000;
    cmp_en = 1'b0; carry_set = 1'b1; carry_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset result", int'(result), 0);
    check("R1 reset zero", int'(zero_flag), 0);
    check("R1 reset carry", int'(carry_flag), 0);
    load_b = 1'b0; op_go = 1'b0; carry_set = 1'b0;
    rst_n = 1'b1;
    // R1: B reset to zero, observed through an add without loading B
    data_in = 8'h05; mode = 3'b000; op_go = 1'b1;
    @(negedge clk);
    op_go = 1'b0;
    check("R1 B cleared by reset", int'(result), 8'h05);
    exp_res = 5; exp_c = 0;

    // R2: same-edge load and operation uses the old B
    data_in = 8'h03; load_b = 1'b1; carry_clr = 1'b1;
    @(negedge clk);
    data_in = 8'h0A; op_go = 1'b1; carry_clr = 1'b0; mode = 3'b000;
    @(negedge clk);
    check("R2 old B used", int'(result), 8'h0D);
    data_in = 8'h01; load_b = 1'b0;
    @(negedge clk);
    op_go = 1'b0;
    check("R2 new B captured", int'(result), 8'h0B);
    exp_res = 8'h0B; exp_c = 0;

    // R10: clear priority, result and zero untouched
    carry_set = 1'b1; carry_clr = 1'b0;
    @(negedge clk);
    check("R10 set", int'(carry_flag), 1);
    carry_clr = 1'b1;
    @(negedge clk);
    carry_set = 1'b0; carry_clr = 1'b0;
    check("R10 clear wins", int'(carry_flag), 0);
    check("R10 result untouched", int'(result), 8'h0B);
    check("R10 zero untouched", int'(zero_flag), 0);

    // R10: set ignored during an operation (AND keeps carry 0)
    data_in = 8'hF0; op_go = 1'b1; mode = 3'b100; carry_set = 1'b1;
    @(negedge clk);
    op_go = 1'b0; carry_set = 1'b0;
    check("R10 set ignored with op_go", int'(carry_flag), 0);

    // Sweeps: R3 add, R4 subtract, R6 logic, R8 compare
    for (int m = 0; m < 8; m++) begin
      if (m == 2 || m == 3 || m == 7) continue;
      for (int ai = 0; ai < 256; ai++)
        for (int bi = 0; bi < 8; bi++)
          for (int ci = 0; ci < 2; ci++)
            case (m)
              0: do_op(ai, bpick(bi), 0, 1'b0, ci, "R3 add");
              1: do_op(ai, bpick(bi), 1, 1'b0, ci, "R4 sub");
              4: do_op(ai, bpick(bi), 4, 1'b0, ci, "R6 and");
              5: do_op(ai, bpick(bi), 5, 1'b0, ci, "R6 or");
              default: do_op(ai, bpick(bi), 6, 1'b0, ci, "R6 xor");
            endcase
    end
    for (int ai = 0; ai < 256; ai++)
      for (int bi = 0; bi < 8; bi++)
        for (int ci = 0; ci < 2; ci++)
          do_op(ai, bpick(bi), (ai + bi) % 8, 1'b1, ci, "R8 compare");

    // R5 increment/decrement, R7 shift right
    for (int ai = 0; ai < 256; ai++)
      for (int ci = 0; ci < 2; ci++) begin
        do_op(ai, 255 - ai, 2, 1'b0, ci, "R5 inc");
        do_op(ai, ai, 3, 1'b0, ci, "R5 dec");
        do_op(ai, 8'h5A, 7, 1'b0, ci, "R7 shr");
      end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule